// File: doc/BRIEF.md
# I2C Master Register and Interrupt Front End

This block is the register file and interrupt collector for a byte-oriented I2C master. A host reaches it over a simple 32-bit register bus: a word index, a write enable, write data and combinational read data. It holds the control word, the two clock-phase counts and the outgoing byte. Each command write is forwarded to the bus engine as a single-cycle strobe. Incoming bytes are captured from the engine.

The bus engine reports seven kinds of event as single-cycle pulses. The block keeps each one as a sticky pending flag until the host clears it through a write-one-to-clear register. Pending flags pass through a per-source unmask, a global unmask and a controller enable before they reach a single level interrupt line. The host can clear exactly the events it has seen by writing the status word it just read into the clear register. The I2C wire signalling is handled by a separate engine.

Top module: `i2cm_csr_front`

## Requirements
- R1: After reset, every register reads zero, `irq` is 0, `cmd_stb` is 0 and `ctl_enable` is 0.
- R2: Word 0 (control) holds bit 8 enable, bit 7 global unmask and bits 6..0 per-source unmasks. Words 4 and 5 hold the 16-bit high and low clock counts. Word 6 holds the 8-bit transmit byte. All of these read back what was written, and the unused upper bits read as zero.
- R3: A write to word 1 raises `cmd_stb` for exactly the next cycle, with `cmd_bits` equal to write data bits 4..0. Reads of word 1 and word 2 return zero.
- R4: Word 3 (status) returns the live `eng_busy` in bit 7 and the pending flags in bits 6..0. The event order in those bits is start (6), end (5), send (4), receive (3), ack error (2), arbitration loss (1) and operation over (0), matching `eng_evt`.
- R5: A pulse on `eng_evt[n]` sets pending flag n from the next cycle, and the flag stays set after the pulse ends.
- R6: Writing word 2 clears each pending flag whose data bit (6..0) is 1 and leaves the others unchanged. Bit 7 is ignored, so writing back a status value read from word 3 clears exactly the flags that were set.
- R7: If an event pulse and a clear of the same flag occur in the same cycle, the flag stays set.
- R8: `irq` is 1 exactly when control bits 8 and 7 are both 1 and some pending flag has its unmask bit set. It follows register state, so it changes the cycle after the causing write or event.
- R9: Writing 0 to control drives `ctl_enable` and `irq` to 0, even while flags are pending.
- R10: The receive byte (word 7) loads `eng_rx_byte` only in a cycle where `eng_rx_done` is 1. Host writes to word 7 are ignored.
- R11: Host writes to the status word have no effect on the pending flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Word index (byte offset divided by four) |
| bus_wr | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| eng_evt | input | 7 | Event pulses from the bus engine |
| eng_busy | input | 1 | Live bus-busy flag |
| eng_rx_done | input | 1 | Received byte valid |
| eng_rx_byte | input | 8 | Received byte |
| cmd_stb | output | 1 | One-cycle command strobe |
| cmd_bits | output | 5 | Command bits that go with the strobe |
| ctl_enable | output | 1 | Controller enable |
| scl_hi_cnt | output | 16 | Clock high-phase count |
| scl_lo_cnt | output | 16 | Clock low-phase count |
| tx_byte | output | 8 | Byte to transmit |
| irq | output | 1 | Level interrupt |

## Verification
The pending logic is driven with single and multi-bit event pulses, partial clears, a full status write-back that has busy set in bit 7, and an event that lands in the same cycle as its own clear. These cases separate a correct set-dominant update from one that gives the clear priority or that treats bit 7 as a flag. The interrupt is tried under each masking level in turn: enable alone, enable with global unmask but the wrong source unmasked, the full unmask, and a control write of zero. This shows whether all three gates are present and whether any one of them was dropped. Writes to the read-only words check that those words cannot be changed from the bus.

// File: rtl/i2cm_csr_pkg.sv
package i2cm_csr_pkg;
  localparam int NEVT  = 7;
  localparam int NREG  = 8;
  localparam int IDX_W = $clog2(NREG);

  typedef enum logic [IDX_W-1:0] {
    RA_CTL  = 3'd0,
    RA_CMD  = 3'd1,
    RA_CLR  = 3'd2,
    RA_STAT = 3'd3,
    RA_SCLH = 3'd4,
    RA_SCLL = 3'd5,
    RA_TX   = 3'd6,
    RA_RX   = 3'd7
  } reg_idx_e;

  // Set-dominant sticky update: new events win over a same-cycle clear.
  function automatic logic [NEVT-1:0] pend_update(input logic [NEVT-1:0] pend,
                                                  input logic [NEVT-1:0] evt,
                                                  input logic [NEVT-1:0] clr);
    return (pend & ~clr) | evt;
  endfunction

  function automatic logic irq_level(input logic en, input logic gun,
                                     input logic [NEVT-1:0] unm,
                                     input logic [NEVT-1:0] pend);
    return en & gun & (|(pend & unm));
  endfunction
endpackage

// File: rtl/i2cm_pend_bank.sv
module i2cm_pend_bank
  import i2cm_csr_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NEVT-1:0] evt,
  input  logic            clr_we,
  input  logic [NEVT-1:0] clr_mask,
  output logic [NEVT-1:0] pend
);
  logic [NEVT-1:0] clr_eff;
  assign clr_eff = clr_we ? clr_mask : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) pend <= '0;
    else        pend <= pend_update(pend, evt, clr_eff);
  end

  // R5
  evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> ((pend & $past(evt)) == $past(evt)));
  // R6
  clr_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_eff != '0) |=> ((pend & $past(clr_eff & ~evt)) == '0));
  // R7
  evt_beats_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt & clr_eff) != '0) |=> ((pend & $past(evt & clr_eff)) == $past(evt & clr_eff)));
  // R11
  no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend & ~$past(pend) & ~$past(evt)) == '0));
endmodule

// File: rtl/i2cm_rd_mux.sv
module i2cm_rd_mux
  import i2cm_csr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [NREG-1:0][DATA_W-1:0] words,
  input  logic [IDX_W-1:0]            idx,
  output logic [DATA_W-1:0]           rdata
);
  assign rdata = words[idx];
endmodule

// File: rtl/i2cm_csr_front.sv
module i2cm_csr_front
  import i2cm_csr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int CMD_W  = 5,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NEVT-1:0]   eng_evt,
  input  logic              eng_busy,
  input  logic              eng_rx_done,
  input  logic [BYTE_W-1:0] eng_rx_byte,
  output logic              cmd_stb,
  output logic [CMD_W-1:0]  cmd_bits,
  output logic              ctl_enable,
  output logic [CNT_W-1:0]  scl_hi_cnt,
  output logic [CNT_W-1:0]  scl_lo_cnt,
  output logic [BYTE_W-1:0] tx_byte,
  output logic              irq
);
  localparam int CTL_W = NEVT + 2;
  localparam int EN_B  = NEVT + 1;
  localparam int GUN_B = NEVT;

  logic [NREG-1:0] wr_hit;
  genvar g;
  generate
    for (g = 0; g < NREG; g++) begin : g_hit
      assign wr_hit[g] = bus_wr && (bus_addr == IDX_W'(g));
    end
  endgenerate

  logic wdata_hi_unused;
  assign wdata_hi_unused = ^bus_wdata[DATA_W-1:CNT_W];

  logic [CTL_W-1:0]  ctl_q;
  logic [CNT_W-1:0]  sclh_q, scll_q;
  logic [BYTE_W-1:0] tx_q, rx_q;
  logic              stb_q;
  logic [CMD_W-1:0]  cmd_q;
  logic [NEVT-1:0]   pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      sclh_q <= '0;
      scll_q <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
      stb_q  <= 1'b0;
      cmd_q  <= '0;
    end else begin
      stb_q <= wr_hit[RA_CMD];
      if (wr_hit[RA_CMD])  cmd_q  <= bus_wdata[CMD_W-1:0];
      if (wr_hit[RA_CTL])  ctl_q  <= bus_wdata[CTL_W-1:0];
      if (wr_hit[RA_SCLH]) sclh_q <= bus_wdata[CNT_W-1:0];
      if (wr_hit[RA_SCLL]) scll_q <= bus_wdata[CNT_W-1:0];
      if (wr_hit[RA_TX])   tx_q   <= bus_wdata[BYTE_W-1:0];
      if (eng_rx_done)     rx_q   <= eng_rx_byte;
    end
  end

  i2cm_pend_bank u_pend (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt      (eng_evt),
    .clr_we   (wr_hit[RA_CLR]),
    .clr_mask (bus_wdata[NEVT-1:0]),
    .pend     (pend)
  );

  logic [NREG-1:0][DATA_W-1:0] words;
  always_comb begin
    words          = '0;
    words[RA_CTL]  = DATA_W'(ctl_q);
    words[RA_STAT] = DATA_W'({eng_busy, pend});
    words[RA_SCLH] = DATA_W'(sclh_q);
    words[RA_SCLL] = DATA_W'(scll_q);
    words[RA_TX]   = DATA_W'(tx_q);
    words[RA_RX]   = DATA_W'(rx_q);
  end

  i2cm_rd_mux #(.DATA_W(DATA_W)) u_rd (
    .words (words),
    .idx   (bus_addr),
    .rdata (bus_rdata)
  );

  assign cmd_stb    = stb_q;
  assign cmd_bits   = cmd_q;
  assign ctl_enable = ctl_q[EN_B];
  assign scl_hi_cnt = sclh_q;
  assign scl_lo_cnt = scll_q;
  assign tx_byte    = tx_q;
  assign irq        = irq_level(ctl_q[EN_B], ctl_q[GUN_B], ctl_q[NEVT-1:0], pend);

  // R3
  cmd_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit[RA_CMD] |=> (cmd_stb && cmd_bits == $past(bus_wdata[CMD_W-1:0])));
  // R3
  cmd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit[RA_CMD] |=> !cmd_stb);
  // R9
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_enable |-> !irq);
  // R8
  irq_needs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend == '0) |-> !irq);
  // R10
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !eng_rx_done |=> $stable(rx_q));
endmodule

// File: tb/test_i2cm_csr_front.sv
module test_i2cm_csr_front;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  a = '0;
  logic        wr = 1'b0;
  logic [31:0] wd = '0;
  logic [6:0]  ev = '0;
  logic        busy = 1'b0;
  logic        rxd = 1'b0;
  logic [7:0]  rxb = '0;
  logic [31:0] rdata;
  logic        stb, en, irq;
  logic [4:0]  cbits;
  logic [15:0] sh, sl;
  logic [7:0]  txb;

  always #2.5 clk = ~clk;

  i2cm_csr_front i_i2cm_csr_front (
    .clk(clk), .rst_n(rst_n), .bus_addr(a), .bus_wr(wr), .bus_wdata(wd),
    .bus_rdata(rdata), .eng_evt(ev), .eng_busy(busy), .eng_rx_done(rxd),
    .eng_rx_byte(rxb), .cmd_stb(stb), .cmd_bits(cbits), .ctl_enable(en),
    .scl_hi_cnt(sh), .scl_lo_cnt(sl), .tx_byte(txb), .irq(irq)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  string scen = "reset";

  // behavioural model state
  int m_ctl = 0, m_hi = 0, m_lo = 0, m_tx = 0, m_rx = 0, m_pend = 0, m_cmd = 0;
  bit m_stb = 0;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s [%s] actual=%0h expected=%0h", tag, scen, act, exp);
    end
  endtask

  function automatic int exp_rd(int idx);
    case (idx)
      0: return m_ctl;
      3: return (busy ? 128 : 0) | m_pend;
      4: return m_hi;
      5: return m_lo;
      6: return m_tx;
      7: return m_rx;
      default: return 0;
    endcase
  endfunction

  task automatic compare_all();
    bit eirq;
    eirq = ((m_ctl >> 8) & 1) && ((m_ctl >> 7) & 1) && ((m_pend & m_ctl & 'h7F) != 0);
    chk("R8", int'(irq), int'(eirq));
    chk("R9", int'(en), (m_ctl >> 8) & 1);
    chk("R3", int'(stb), int'(m_stb));
    if (m_stb) chk("R3", int'(cbits), m_cmd);
    chk("R2", int'(sh), m_hi);
    chk("R2", int'(sl), m_lo);
    chk("R2", int'(txb), m_tx);
    case (int'(a))
      1, 2: chk("R3", int'(rdata), exp_rd(int'(a)));
      3:    chk("R4", int'(rdata), exp_rd(3));
      7:    chk("R10", int'(rdata), exp_rd(7));
      default: chk("R2", int'(rdata), exp_rd(int'(a)));
    endcase
  endtask

  task automatic step();
    int idx, clr;
    @(posedge clk);
    idx = int'(a);
    m_stb = wr && idx == 1;
    if (m_stb) m_cmd = wd & 'h1F;
    if (wr && idx == 0) m_ctl = wd & 'h1FF;
    if (wr && idx == 4) m_hi = wd & 'hFFFF;
    if (wr && idx == 5) m_lo = wd & 'hFFFF;
    if (wr && idx == 6) m_tx = wd & 'hFF;
    clr = (wr && idx == 2) ? (wd & 'h7F) : 0;
    m_pend = (m_pend & ~clr) | int'(ev);
    if (rxd) m_rx = int'(rxb);
    @(negedge clk);
    compare_all();
  endtask

  task automatic bus_write(int idx, int data);
    a = 3'(idx); wr = 1'b1; wd = data;
    step();
    wr = 1'b0; wd = '0;
  endtask

  task automatic pulse(int e);
    ev = 7'(e);
    step();
    ev = '0;
  endtask

  task automatic read_at(int idx);
    a = 3'(idx);
    step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int sv;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state, every word reads zero
    scen = "R1 reset";
    compare_all();
    for (int i = 0; i < 8; i++) begin a = 3'(i); #0.1; chk("R1", int'(rdata), 0); end
    a = '0;

    // R2 control / count / tx write and read back with upper bits dropped
    scen = "R2 readback";
    bus_write(4, 'h0012_3456);
    bus_write(5, 'hFFFF_ABCD);
    bus_write(6, 'h0000_03A5);
    bus_write(0, 'hFFFF_FE00);
    for (int i = 0; i < 8; i++) read_at(i);

    // R3 command strobe, back-to-back, and zero readback
    scen = "R3 command";
    bus_write(1, 'h0000_00F3);
    bus_write(1, 'h0000_000A);
    read_at(1);
    read_at(2);

    // R5 events set sticky flags; R4 status with busy
    scen = "R5 event sticky";
    busy = 1'b1;
    bus_write(0, 'h1FF);
    pulse('b100_0001);
    read_at(3);
    pulse('b001_0010);
    read_at(3);

    // R6 partial clear, then full write-back including bit 7
    scen = "R6 clear";
    bus_write(2, 'h0000_0001);
    read_at(3);
    sv = int'(rdata);
    bus_write(2, sv);
    read_at(3);
    chk("R6", int'(rdata) & 'h7F, 0);

    // R7 event and clear of same flag in one cycle
    scen = "R7 same cycle";
    ev = 7'b000_0100;
    bus_write(2, 'h04);
    ev = '0;
    read_at(3);
    chk("R7", int'(rdata) & 4, 4);

    // R8 masking levels
    scen = "R8 enable only";
    bus_write(0, 'h17F);
    read_at(3);
    scen = "R8 wrong source";
    bus_write(0, 'h183);
    read_at(3);
    scen = "R8 full unmask";
    bus_write(0, 'h184);
    read_at(3);
    chk("R8", int'(irq), 1);

    // R9 control zero masks everything
    scen = "R9 disable";
    bus_write(0, 0);
    read_at(3);
    chk("R9", int'(irq), 0);

    // R10 rx: bus write ignored, engine load
    scen = "R10 rx";
    bus_write(7, 'h55);
    read_at(7);
    rxb = 8'h9C; rxd = 1'b1;
    step();
    rxd = 1'b0; rxb = 8'h11;
    read_at(7);
    chk("R10", int'(rdata), 'h9C);

    // R11 status writes ignored
    scen = "R11 status write";
    pulse('b111_0000);
    bus_write(3, 'h0000_00FF);
    read_at(3);
    bus_write(3, 0);
    read_at(3);
    chk("R11", int'(rdata) & 'h70, 'h70);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule